// File: doc/BRIEF.md
# Per-Window Shadow Register Bank

This block keeps the programming state of a set of overlay windows in two layers. A bus port writes the staging layer: for each window a visibility flag, a frame buffer start address, a frame buffer end address and a screen position word. The display pipeline sees only the active layer. Staging values move into the active layer at a frame boundary, which a one-cycle `vsync_i` pulse marks. The active layer does not change at any other time.

A shared control word holds one protect bit and one channel-enable bit for each window. While a window's protect bit is set, that window's whole staged set stays back at every frame boundary. Software can therefore rewrite several fields without the pipeline ever picking up a half-written set. When the bit is cleared, the complete set moves across together at the next pulse. All unprotected windows transfer in the same clock cycle. Software can read back both the staged and the active buffer start address of each window. When the two are equal, the update has landed.

Address layout: `addr = {window[2:0], offset[2:0]}`. The offsets within a window are 0 control (bit 0 = visible), 1 staged start, 2 staged end, 3 position, and 4 active start (read-only). Window field 7 with offset 0 selects the shared control word: bit w is the protect bit and bit 8+w is the channel enable of window w.

Top module: `win_shadow_bank`

## Requirements
- R1: After reset, every staged and active field, every protect bit and every channel-enable bit is zero, so all active outputs and all readbacks are 0.
- R2: A write to offsets 0 to 3 of window w changes only that window's staging, which reads back immediately. The active outputs stay unchanged until a vsync pulse.
- R3: In the clock cycle in which `vsync_i` is high, an unprotected window copies its staged visible flag, start, end, position and channel-enable bit into the active layer. The new values appear on the outputs after that clock edge. `act_on_o[w]` equals the active visible flag AND the active channel enable.
- R4: A vsync pulse leaves a window's active layer unchanged while its protect bit (control bit w) is set, even if its staging has changed.
- R5: After the protect bit is cleared, the next vsync pulse transfers the complete pending staged set.
- R6: All unprotected windows transfer at the same vsync edge.
- R7: A bus write in the same cycle as the vsync pulse lands in staging. The active layer takes the previous staged value, and the new value transfers at the following pulse.
- R8: Offset 1 reads the staged start address and offset 4 reads the active start address. They are equal once an update has transferred.
- R9: Clearing the visible flag (offset 0 bit 0) hides the window only after the next vsync pulse.
- R10: The control word at address 0x38 holds the protect bits in [NUM_WIN-1:0] and the channel-enable bits in [8+NUM_WIN-1:8]. It reads back as written and is not affected by vsync.
- R11: Writes to offset 4 and to unmapped addresses are ignored. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | One-cycle frame boundary pulse |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 6 | Bus write address |
| wr_data_i | input | 32 | Bus write data |
| rd_addr_i | input | 6 | Bus read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| act_on_o | output | 5 | Per-window active visibility |
| act_start_o | output | 160 | Active start address, window w at [32w+31:32w] |
| act_end_o | output | 160 | Active end address, window w at [32w+31:32w] |
| act_pos_o | output | 160 | Active position word, window w at [32w+31:32w] |

## Verification
Suppose the transfer gate were wrong: it ignored protect, missed a window, or fired off the pulse. The active start readback and the active output ports would then differ from the staged value in the first cycle after the offending vsync edge, so each check samples exactly one edge after the pulse. A wrong staging write shows up at once in the offset 1 readback, before any pulse. A leaked write to the read-only offset would show in the offset 4 readback and on `act_start_o` without any pulse at all.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_CTRL      = 3'd0,
    OFF_START     = 3'd1,
    OFF_END       = 3'd2,
    OFF_POS       = 3'd3,
    OFF_ACT_START = 3'd4
  } win_off_e;

  localparam int CHAN_LSB = 8;
endpackage

// File: rtl/shadow_ctrl_reg.sv
module shadow_ctrl_reg #(
  parameter int NUM_WIN = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [NUM_WIN-1:0] prot_d_i,
  input  logic [NUM_WIN-1:0] chan_d_i,
  output logic [NUM_WIN-1:0] prot_o,
  output logic [NUM_WIN-1:0] chan_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_o <= '0;
      chan_o <= '0;
    end else if (wr_en_i) begin
      prot_o <= prot_d_i;
      chan_o <= chan_d_i;
    end
  end

  // R10: control word changes only through its own write
  assert_ctrl_write_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(prot_o) && $stable(chan_o)));
endmodule

// File: rtl/shadow_window.sv
module shadow_window
  import shadow_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vsync_i,
  input  logic             prot_i,
  input  logic             chan_i,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             stg_en_o,
  output logic [DW-1:0]    stg_start_o,
  output logic [DW-1:0]    stg_end_o,
  output logic [DW-1:0]    stg_pos_o,
  output logic             act_on_o,
  output logic [DW-1:0]    act_start_o,
  output logic [DW-1:0]    act_end_o,
  output logic [DW-1:0]    act_pos_o
);
  logic act_en_q, act_chan_q;
  logic xfer;

  assign xfer = vsync_i && !prot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_en_o    <= 1'b0;
      stg_start_o <= '0;
      stg_end_o   <= '0;
      stg_pos_o   <= '0;
    end else if (wr_en_i) begin
      case (win_off_e'(wr_off_i))
        OFF_CTRL:  stg_en_o    <= wr_data_i[0];
        OFF_START: stg_start_o <= wr_data_i;
        OFF_END:   stg_end_o   <= wr_data_i;
        OFF_POS:   stg_pos_o   <= wr_data_i;
        default: ;  // read-only / unmapped
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_q    <= 1'b0;
      act_chan_q  <= 1'b0;
      act_start_o <= '0;
      act_end_o   <= '0;
      act_pos_o   <= '0;
    end else if (xfer) begin
      act_en_q    <= stg_en_o;
      act_chan_q  <= chan_i;
      act_start_o <= stg_start_o;
      act_end_o   <= stg_end_o;
      act_pos_o   <= stg_pos_o;
    end
  end

  assign act_on_o = act_en_q & act_chan_q;

  assert_copy_on_vsync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && !prot_i) |=> (act_start_o == $past(stg_start_o) &&
                               act_end_o == $past(stg_end_o) &&
                               act_pos_o == $past(stg_pos_o) &&
                               act_on_o == ($past(stg_en_o) && $past(chan_i))));

  assert_hold_when_protected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && prot_i) |=> ($stable(act_start_o) && $stable(act_end_o) &&
                             $stable(act_pos_o) && $stable(act_on_o)));

  assert_quiet_between_frames_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> ($stable(act_start_o) && $stable(act_end_o) &&
                  $stable(act_pos_o) && $stable(act_on_o)));
endmodule

// File: rtl/shadow_read_mux.sv
module shadow_read_mux
  import shadow_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int DW      = 32,
  parameter int WIN_AW  = 3
) (
  input  logic [WIN_AW+OFF_W-1:0] rd_addr_i,
  input  logic [NUM_WIN-1:0]      stg_en_i,
  input  logic [NUM_WIN*DW-1:0]   stg_start_i,
  input  logic [NUM_WIN*DW-1:0]   stg_end_i,
  input  logic [NUM_WIN*DW-1:0]   stg_pos_i,
  input  logic [NUM_WIN*DW-1:0]   act_start_i,
  input  logic [NUM_WIN-1:0]      prot_i,
  input  logic [NUM_WIN-1:0]      chan_i,
  output logic [DW-1:0]           rd_data_o
);
  localparam logic [WIN_AW-1:0] CTRL_WIN = '1;

  logic [WIN_AW-1:0] rd_win;
  logic [OFF_W-1:0]  rd_off;

  assign rd_win = rd_addr_i[OFF_W +: WIN_AW];
  assign rd_off = rd_addr_i[OFF_W-1:0];

  always_comb begin
    rd_data_o = '0;
    if (rd_win == CTRL_WIN && rd_off == '0) begin
      rd_data_o[NUM_WIN-1:0]                = prot_i;
      rd_data_o[CHAN_LSB +: NUM_WIN]        = chan_i;
    end
    for (int w = 0; w < NUM_WIN; w++) begin
      if (rd_win == WIN_AW'(w)) begin
        case (win_off_e'(rd_off))
          OFF_CTRL:      rd_data_o = DW'(stg_en_i[w]);
          OFF_START:     rd_data_o = stg_start_i[w*DW +: DW];
          OFF_END:       rd_data_o = stg_end_i[w*DW +: DW];
          OFF_POS:       rd_data_o = stg_pos_i[w*DW +: DW];
          OFF_ACT_START: rd_data_o = act_start_i[w*DW +: DW];
          default:       rd_data_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank
  import shadow_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int DW      = 32,
  localparam int WIN_AW = $clog2(NUM_WIN + 1),
  localparam int AW     = WIN_AW + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vsync_i,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NUM_WIN-1:0] act_on_o,
  output logic [NUM_WIN*DW-1:0] act_start_o,
  output logic [NUM_WIN*DW-1:0] act_end_o,
  output logic [NUM_WIN*DW-1:0] act_pos_o
);
  localparam logic [WIN_AW-1:0] CTRL_WIN = '1;

  logic [WIN_AW-1:0] wr_win;
  logic [OFF_W-1:0]  wr_off;
  logic              ctrl_we;
  logic [NUM_WIN-1:0] prot, chan, stg_en;
  logic [NUM_WIN*DW-1:0] stg_start, stg_end, stg_pos;

  assign wr_win  = wr_addr_i[OFF_W +: WIN_AW];
  assign wr_off  = wr_addr_i[OFF_W-1:0];
  assign ctrl_we = wr_en_i && wr_win == CTRL_WIN && wr_off == '0;

  shadow_ctrl_reg #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (ctrl_we),
    .prot_d_i (wr_data_i[NUM_WIN-1:0]),
    .chan_d_i (wr_data_i[CHAN_LSB +: NUM_WIN]),
    .prot_o   (prot),
    .chan_o   (chan)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic win_we;
    assign win_we = wr_en_i && wr_win == WIN_AW'(w);

    shadow_window #(.DW(DW)) u_win (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .vsync_i     (vsync_i),
      .prot_i      (prot[w]),
      .chan_i      (chan[w]),
      .wr_en_i     (win_we),
      .wr_off_i    (wr_off),
      .wr_data_i   (wr_data_i),
      .stg_en_o    (stg_en[w]),
      .stg_start_o (stg_start[w*DW +: DW]),
      .stg_end_o   (stg_end[w*DW +: DW]),
      .stg_pos_o   (stg_pos[w*DW +: DW]),
      .act_on_o    (act_on_o[w]),
      .act_start_o (act_start_o[w*DW +: DW]),
      .act_end_o   (act_end_o[w*DW +: DW]),
      .act_pos_o   (act_pos_o[w*DW +: DW])
    );
  end

  shadow_read_mux #(.NUM_WIN(NUM_WIN), .DW(DW), .WIN_AW(WIN_AW)) u_rd (
    .rd_addr_i   (rd_addr_i),
    .stg_en_i    (stg_en),
    .stg_start_i (stg_start),
    .stg_end_i   (stg_end),
    .stg_pos_i   (stg_pos),
    .act_start_i (act_start_o),
    .prot_i      (prot),
    .chan_i      (chan),
    .rd_data_o   (rd_data_o)
  );

  // R6: with nothing protected, every window's active start equals its staged start after a pulse
  assert_all_windows_together_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && prot == '0) |=> (act_start_o == $past(stg_start)));

  // R10: a vsync pulse alone never disturbs the control word
  assert_ctrl_vsync_immune_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && !ctrl_we) |=> ($stable(prot) && $stable(chan)));
endmodule

// File: tb/win_shadow_bank_test.sv
module win_shadow_bank_test;
  localparam int NW = 5;
  localparam int DW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vsync_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [5:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [5:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [NW-1:0] act_on_o;
  logic [NW*DW-1:0] act_start_o, act_end_o, act_pos_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  win_shadow_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .vsync_i(vsync_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .act_on_o(act_on_o), .act_start_o(act_start_o),
    .act_end_o(act_end_o), .act_pos_o(act_pos_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, called and returning at a falling edge
  task automatic cyc(input logic we, input logic [5:0] a, input logic [DW-1:0] d, input logic vs);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; vsync_i = vs;
    @(negedge clk_i);
    wr_en_i = 1'b0; vsync_i = 1'b0;
  endtask

  function automatic logic [DW-1:0] rd(input logic [5:0] a);
    rd_addr_i = a;
    return rd_data_o;
  endfunction

  task automatic rcheck(input string req, input logic [5:0] a, input logic [DW-1:0] exp);
    rd_addr_i = a;
    #1;
    check(req, rd_data_o, exp);
  endtask

  // {op, req, addr, data, expect}; op 0 write, 1 vsync, 2 read-check, 3 write+vsync
  localparam int NV = 19;
  localparam logic [87:0] VEC [NV] = '{
    {8'd0, 8'd2,  8'h11, 32'h0000_1000, 32'h0},           // R2 stage w2 start
    {8'd2, 8'd2,  8'h11, 32'h0,         32'h0000_1000},   // R2 staged readback
    {8'd2, 8'd2,  8'h14, 32'h0,         32'h0},           // R2 active untouched
    {8'd1, 8'd3,  8'h00, 32'h0,         32'h0},
    {8'd2, 8'd3,  8'h14, 32'h0,         32'h0000_1000},   // R3 transferred
    {8'd0, 8'd4,  8'h38, 32'h0000_0004, 32'h0},           // R4 protect w2
    {8'd0, 8'd4,  8'h11, 32'h0000_2000, 32'h0},
    {8'd1, 8'd4,  8'h00, 32'h0,         32'h0},
    {8'd2, 8'd4,  8'h14, 32'h0,         32'h0000_1000},   // R4 held back
    {8'd0, 8'd5,  8'h38, 32'h0,         32'h0},           // R5 release
    {8'd2, 8'd5,  8'h14, 32'h0,         32'h0000_1000},   // R5 not before pulse
    {8'd1, 8'd5,  8'h00, 32'h0,         32'h0},
    {8'd2, 8'd5,  8'h14, 32'h0,         32'h0000_2000},   // R5 applied
    {8'd3, 8'd7,  8'h11, 32'h0000_3000, 32'h0},           // R7 write with pulse
    {8'd2, 8'd7,  8'h14, 32'h0,         32'h0000_2000},   // R7 old value moved
    {8'd1, 8'd7,  8'h00, 32'h0,         32'h0},
    {8'd2, 8'd7,  8'h14, 32'h0,         32'h0000_3000},   // R7 new value next pulse
    {8'd0, 8'd11, 8'h14, 32'h0000_DEAD, 32'h0},           // R11 write to read-only
    {8'd2, 8'd11, 8'h14, 32'h0,         32'h0000_3000}    // R11 ignored
  };

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state, sampled while still in reset and after release
    check("R1", DW'(act_on_o), 32'h0);
    check("R1", act_start_o[2*DW +: DW], 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rcheck("R1", 6'h38, 32'h0);
    rcheck("R1", 6'h11, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] op, rq;
      logic [5:0] a;
      logic [31:0] d, e;
      op = VEC[i][87:80]; rq = VEC[i][79:72]; a = VEC[i][69:64];
      d = VEC[i][63:32]; e = VEC[i][31:0];
      case (op)
        8'd0: cyc(1'b1, a, d, 1'b0);
        8'd1: cyc(1'b0, a, d, 1'b1);
        8'd3: cyc(1'b1, a, d, 1'b1);
        default: rcheck($sformatf("R%0d vec%0d", rq, i), a, e);
      endcase
    end
    check("R11", act_start_o[2*DW +: DW], 32'h0000_3000);
    rcheck("R11", 6'h3F, 32'h0);
    rcheck("R11", 6'h2F, 32'h0);

    // R3 full set on window 0 with channel enable
    cyc(1'b1, 6'h00, 32'h1, 1'b0);
    cyc(1'b1, 6'h01, 32'h0000_A000, 1'b0);
    cyc(1'b1, 6'h02, 32'h0000_B000, 1'b0);
    cyc(1'b1, 6'h03, 32'h0020_0010, 1'b0);
    cyc(1'b1, 6'h38, 32'h0000_0100, 1'b0);
    check("R3 before", DW'(act_on_o[0]), 32'h0);
    cyc(1'b0, 6'h00, 32'h0, 1'b1);
    check("R3 on", DW'(act_on_o[0]), 32'h1);
    check("R3 start", act_start_o[0 +: DW], 32'h0000_A000);
    check("R3 end", act_end_o[0 +: DW], 32'h0000_B000);
    check("R3 pos", act_pos_o[0 +: DW], 32'h0020_0010);
    rcheck("R10", 6'h38, 32'h0000_0100);

    // R6 several windows at one pulse
    cyc(1'b1, 6'h09, 32'h0000_1111, 1'b0);
    cyc(1'b1, 6'h21, 32'h0000_4444, 1'b0);
    cyc(1'b1, 6'h01, 32'h0000_C000, 1'b0);
    cyc(1'b0, 6'h00, 32'h0, 1'b1);
    check("R6 w1", act_start_o[1*DW +: DW], 32'h0000_1111);
    check("R6 w4", act_start_o[4*DW +: DW], 32'h0000_4444);
    check("R6 w0", act_start_o[0 +: DW], 32'h0000_C000);
    // R8 staged and active start agree after transfer
    rcheck("R8 staged", 6'h01, 32'h0000_C000);
    rcheck("R8 active", 6'h04, 32'h0000_C000);

    // R9 hiding waits for the frame boundary
    cyc(1'b1, 6'h00, 32'h0, 1'b0);
    check("R9 still on", DW'(act_on_o[0]), 32'h1);
    cyc(1'b0, 6'h00, 32'h0, 1'b1);
    check("R9 off", DW'(act_on_o[0]), 32'h0);
    rcheck("R10 vsync immune", 6'h38, 32'h0000_0100);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule